// File: doc/BRIEF.md
# Shift-Register Period Meter

This unit finds out how many clock steps a Galois-style linear feedback shift register needs to come back to its starting state. A single-cycle start strobe loads three things: a seed, a feedback polynomial and a stage count. The unit then advances the register by one step per clock. It counts the steps until the register state matches the captured seed again. It reports that count with a one-cycle done pulse. It also sets a flag when the count equals 2^n - 1, which means the polynomial and seed gave a maximal-length sequence.

Control is a three-state machine:
- **IDLE**: waits for a start.
- **RUN**: advances the register and the step counter.
- **REPORT**: raises done for one cycle.

The named transitions are:
- IDLE→RUN on an accepted start.
- RUN→REPORT on a seed match.
- RUN→IDLE on abort.
- REPORT→IDLE always.

A stage-count input of zero, or one above the maximum, is treated as the maximum.

Top module: `lfsr_period_meter`

## Requirements
- R1: After reset, busy, done, period and is_maximal are all 0.
- R2: A start seen while idle loads the inputs, with the seed masked to its low n bits. busy reads 1 from the following cycle, and period and is_maximal read 0 until a result is loaded.
- R3: One step shifts the state left by one bit. If bit n-1 of the old state is 1, poly is XORed in, where poly bit j is the coefficient of D^j for j < n and the D^n term is implicit. Bits at n and above are cleared.
- R4: If the start is taken at clock edge k and the state first equals the seed after P steps, then done is 1 between edges k+P and k+P+1. At that point period reads P, and busy has been 1 throughout.
- R5: With feedback only into stage 0 (poly 0001, n=4), seed 1011 gives period 4 and seed 1010 gives period 2.
- R6: With poly 0101 (D^4+D^2+1), seeds 1011 and 1010 give period 6 and seed 0111 gives period 3.
- R7: An all-zero seed gives period 1.
- R8: is_maximal is 1 exactly when period equals 2^n - 1. This holds for every nonzero seed under D^4+D^3+1 (period 15), under D^3+D+1 (period 7), and under D^16+D^5+D^3+D^2+1 (period 65535). It does not hold for poly 0101.
- R9: done is 1 for exactly one cycle. period and is_maximal hold their values until the next accepted start.
- R10: A start while busy is ignored, and the running measurement finishes with its original result.
- R11: abort while measuring returns the unit to idle on the next edge, with no done pulse, and period stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a measurement (taken only while idle) |
| abort | input | 1 | Cancel a measurement in progress |
| seed | input | N_MAX | Starting state |
| poly | input | N_MAX | Feedback coefficients, bit j = D^j |
| len | input | LEN_W | Stage count n (0 or above N_MAX means N_MAX) |
| busy | output | 1 | Measurement in progress or reporting |
| done | output | 1 | One-cycle result strobe |
| period | output | N_MAX+1 | Measured step count |
| is_maximal | output | 1 | period equals 2^n - 1 |

## Verification
The bench builds the meter with N_MAX set to 16, which gives 5 stage-count bits and 17 period bits. This keeps a full 16-stage maximal run of 65535 steps within the cycle budget, next to short four-stage loops of period 1, 2, 3, 4, 6 and 15. It also leaves room for upper seed bits that masking must discard, a restart attempted mid-run, and an abort during a long run.

// File: rtl/lfsr_meas_pkg.sv
package lfsr_meas_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_REPORT = 2'd2
    } meas_state_e;

endpackage

// File: rtl/lfsr_meas_step.sv
// Combinational Galois step for an n-stage register held in N_MAX bits.
module lfsr_meas_step #(
    parameter int N_MAX = 32,
    parameter int LEN_W = $clog2(N_MAX + 1)
) (
    input  logic [N_MAX-1:0] cur,
    input  logic [N_MAX-1:0] poly,
    input  logic [LEN_W-1:0] n_stages,
    output logic [N_MAX-1:0] nxt,
    output logic [N_MAX-1:0] live_mask
);

    logic [N_MAX-1:0] top_sel;
    logic             fb;
    logic [N_MAX-1:0] shifted;

    for (genvar j = 0; j < N_MAX; j++) begin : g_bits
        assign live_mask[j] = (LEN_W'(j) < n_stages);
        assign top_sel[j]   = (n_stages == LEN_W'(j + 1));
    end

    always_comb begin
        fb      = |(cur & top_sel);
        shifted = {cur[N_MAX-2:0], 1'b0};
        nxt     = (shifted ^ ({N_MAX{fb}} & poly)) & live_mask;
    end

endmodule

// File: rtl/lfsr_meas_cnt.sv
// Step counter and full-length reference for the maximal judgement.
module lfsr_meas_cnt #(
    parameter int N_MAX = 32,
    parameter int LEN_W = $clog2(N_MAX + 1),
    parameter int CNT_W = N_MAX + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [LEN_W-1:0] n_stages,
    output logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W-1:0] full_len
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_next;
        end
    end

    always_comb begin
        cnt_next = cnt_q + CNT_W'(1);
        full_len = {CNT_W{1'b1}} >> (CNT_W - {{(CNT_W-LEN_W){1'b0}}, n_stages});
    end

endmodule

// File: rtl/lfsr_meas_ctrl.sv
// IDLE -> RUN on start, RUN -> REPORT on seed match, RUN -> IDLE on abort,
// REPORT -> IDLE always.
module lfsr_meas_ctrl
    import lfsr_meas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic hit,
    output logic capture,
    output logic step,
    output logic load_res,
    output logic busy,
    output logic done
);

    meas_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_RUN;
            ST_RUN: begin
                if (abort)    st_d = ST_IDLE;
                else if (hit) st_d = ST_REPORT;
            end
            ST_REPORT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture  = 1'b0;
        step     = 1'b0;
        load_res = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (st_q)
            ST_IDLE:   capture = start;
            ST_RUN: begin
                busy     = 1'b1;
                step     = !abort;
                load_res = !abort && hit;
            end
            ST_REPORT: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lfsr_period_meter.sv
module lfsr_period_meter #(
    parameter int N_MAX = 32,
    parameter int LEN_W = $clog2(N_MAX + 1),
    parameter int CNT_W = N_MAX + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [N_MAX-1:0] seed,
    input  logic [N_MAX-1:0] poly,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] period,
    output logic             is_maximal
);

    logic [LEN_W-1:0] len_eff;
    logic [N_MAX-1:0] in_mask;
    logic [N_MAX-1:0] seed_q, poly_q, lfsr_q;
    logic [LEN_W-1:0] len_q;
    logic [N_MAX-1:0] nxt, live_mask;
    logic [CNT_W-1:0] cnt_next, full_len;
    logic             capture, step, load_res, hit;
    logic [CNT_W-1:0] period_q;
    logic             max_q;

    always_comb begin
        if (len == '0 || len > LEN_W'(N_MAX)) len_eff = LEN_W'(N_MAX);
        else                                  len_eff = len;
        for (int j = 0; j < N_MAX; j++) in_mask[j] = (LEN_W'(j) < len_eff);
    end

    lfsr_meas_step #(.N_MAX(N_MAX), .LEN_W(LEN_W)) u_step (
        .cur(lfsr_q), .poly(poly_q), .n_stages(len_q),
        .nxt(nxt), .live_mask(live_mask)
    );

    assign hit = (nxt == seed_q);

    lfsr_meas_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .hit(hit),
        .capture(capture), .step(step), .load_res(load_res),
        .busy(busy), .done(done)
    );

    lfsr_meas_cnt #(.N_MAX(N_MAX), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(capture), .inc(step),
        .n_stages(len_q), .cnt_next(cnt_next), .full_len(full_len)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q   <= '0;
            poly_q   <= '0;
            len_q    <= LEN_W'(N_MAX);
            lfsr_q   <= '0;
            period_q <= '0;
            max_q    <= 1'b0;
        end else if (capture) begin
            seed_q   <= seed & in_mask;
            poly_q   <= poly;
            len_q    <= len_eff;
            lfsr_q   <= seed & in_mask;
            period_q <= '0;
            max_q    <= 1'b0;
        end else begin
            if (step) lfsr_q <= nxt;
            if (load_res) begin
                period_q <= cnt_next;
                max_q    <= (cnt_next == full_len);
            end
        end
    end

    assign period     = period_q;
    assign is_maximal = max_q;

endmodule

// File: rtl/lfsr_period_meter_chk.sv
module lfsr_period_meter_chk #(
    parameter int CNT_W = 33
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             abort,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] period,
    input logic             is_maximal
);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && period == '0 && !is_maximal));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(period) && $stable(is_maximal)));

    // R11
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && abort) |=> (!busy && !done));

    // R8
    maximal_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_maximal |-> (period != '0));

endmodule

bind lfsr_period_meter lfsr_period_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .busy(busy), .done(done), .period(period), .is_maximal(is_maximal)
);

// File: tb/tb_lfsr_period_meter.sv
module tb_lfsr_period_meter;

    localparam int N  = 16;
    localparam int LW = $clog2(N + 1);
    localparam int CW = N + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic [N-1:0]  seed = '0;
    logic [N-1:0]  poly = '0;
    logic [LW-1:0] len = '0;
    logic          busy, done, is_maximal;
    logic [CW-1:0] period;

    int n_vec = 0;
    int n_bad = 0;

    lfsr_period_meter #(.N_MAX(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .seed(seed), .poly(poly), .len(len),
        .busy(busy), .done(done), .period(period), .is_maximal(is_maximal)
    );

    always #2 clk = ~clk;

    // behavioural reference model
    int      m_st = 0;
    longint  m_seed, m_poly, m_lfsr, m_cnt, m_per, m_mask;
    int      m_n;
    bit      m_max;

    always @(posedge clk) begin
        longint nx;
        if (!rst_n) begin
            m_st = 0; m_per = 0; m_max = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: if (start) begin
                    m_n    = (len == 0 || len > N) ? N : int'(len);
                    m_mask = (longint'(1) << m_n) - 1;
                    m_seed = longint'(seed) & m_mask;
                    m_poly = longint'(poly);
                    m_lfsr = m_seed;
                    m_cnt  = 0; m_per = 0; m_max = 0;
                    m_st   = 1;
                end
                1: if (abort) m_st = 0;
                   else begin
                       nx = m_lfsr * 2;
                       if (((m_lfsr >> (m_n - 1)) & 1) == 1) nx = nx ^ m_poly;
                       nx = nx & m_mask;
                       m_lfsr = nx;
                       m_cnt++;
                       if (nx == m_seed) begin
                           m_per = m_cnt;
                           m_max = (m_cnt == m_mask);
                           m_st  = 2;
                       end
                   end
                default: m_st = 0;
            endcase
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            n_vec++;
            if (busy !== (m_st != 0)) begin
                n_bad++; $display("FAIL R4 busy model act=%0b exp=%0b", busy, m_st != 0);
            end
            if (done !== (m_st == 2)) begin
                n_bad++; $display("FAIL R9 done model act=%0b exp=%0b", done, m_st == 2);
            end
            if (period !== CW'(m_per)) begin
                n_bad++; $display("FAIL R3 period model act=%0d exp=%0d", period, m_per);
            end
            if (is_maximal !== m_max) begin
                n_bad++; $display("FAIL R8 maximal model act=%0b exp=%0b", is_maximal, m_max);
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input logic [N-1:0] s, input logic [N-1:0] p,
                           input int n, input longint exp_p, input bit exp_m,
                           input string req);
        int cyc;
        @(negedge clk);
        seed = s; poly = p; len = LW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy, 1);
        chk("R2 period cleared", period, 0);
        cyc = 0;
        while (!done && cyc < 70000) begin
            @(negedge clk);
            cyc++;
        end
        chk({req, " period"}, period, exp_p);
        chk({req, " maximal"}, is_maximal, exp_m);
        chk("R4 done latency", cyc, exp_p);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 period", period, 0);
        chk("R1 maximal", is_maximal, 0);

        // R5 ring register
        measure(16'h000B, 16'h0001, 4, 4, 0, "R5 ring 1011");
        measure(16'h000A, 16'h0001, 4, 2, 0, "R5 ring 1010");
        // R6
        measure(16'h000B, 16'h0005, 4, 6, 0, "R6 seed 1011");
        measure(16'h000A, 16'h0005, 4, 6, 0, "R6 seed 1010");
        measure(16'h0007, 16'h0005, 4, 3, 0, "R6 seed 0111");
        // R7
        measure(16'h0000, 16'h0009, 4, 1, 0, "R7 zero seed");
        // R8 all nonzero seeds of D^4+D^3+1
        for (int s = 1; s < 16; s++)
            measure(N'(s), 16'h0009, 4, 15, 1, "R8 D4+D3+1");
        // R3 other step rules
        measure(16'h0001, 16'h0003, 4, 15, 1, "R3 D4+D+1");
        measure(16'h0005, 16'h0003, 3, 7, 1, "R3 D3+D+1");
        // R2 upper seed bits discarded
        measure(16'hF0F1, 16'h0009, 4, 15, 1, "R2 seed mask");

        // R9 result held, done single
        repeat (5) begin
            @(negedge clk);
            chk("R9 done low after pulse", done, 0);
            chk("R9 period held", period, 15);
        end

        // R10 start while busy ignored
        @(negedge clk);
        seed = 16'h000B; poly = 16'h0005; len = 4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        seed = 16'h0007; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk("R10 restart ignored period", period, 6);

        // R8 16-stage maximal
        measure(16'h0001, 16'h002D, 16, 65535, 1, "R8 16 stage");

        // R11 abort
        @(negedge clk);
        seed = 16'h0001; poly = 16'h002D; len = 16; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R11 idle after abort", busy, 0);
        repeat (6) begin
            chk("R11 no done", done, 0);
            chk("R11 period zero", period, 0);
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule